// File: doc/BRIEF.md
# Packet Length and Pad Calculator

This block watches a byte-serial packet stream whose headers follow the IPv4 layout. While the header passes, it picks out the 16-bit total-length field and works out how many pad bytes the packet needs. The pad count is chosen so that the packet, its pad and an 8-byte trailer together fill a whole number of 48-byte cells. The length and the pad count stay in registers, where the trailer-building and segmentation stages further down the chain read them.

Every byte leaves the block unchanged after a fixed latency, with its valid and start-of-packet markers. One cycle after both length bytes have been taken, the block raises a single-cycle ready pulse. During that pulse the pad count and an error flag are valid. The error flag marks a length field smaller than the minimum header size.

Top module: `pktlen_pad_calc`

## Requirements
- R1: Every input beat (in_valid, in_sop, in_data) appears unchanged on out_valid, out_sop and out_data exactly FWD_LAT (default 2) clock edges after the edge that accepts it.
- R2: A beat with in_valid and in_sop high is header byte index 0. Later valid beats take indexes 1, 2, 3 and so on. Byte index 2 is the most significant length byte and byte index 3 is the least significant. pkt_len holds the new value after the edge that accepts byte index 3.
- R3: Once computed, pad_cnt equals (48 - ((pkt_len + 8) mod 48)) mod 48, which lies in the range 0 to 47.
- R4: len_ready is high for exactly one cycle for each completed length capture, starting one cycle after pkt_len updates, and pad_cnt and len_err are valid in that cycle.
- R5: A length field smaller than 20 sets len_err high together with the ready pulse and sets pad_cnt to 0.
- R6: A valid start-of-packet beat clears len_ready and len_err on the next edge, restarts the byte index, and cancels any computation still pending. pad_cnt keeps its previous value in that case.
- R7: Beats with in_valid low do not advance the byte index. Bytes beyond index 3 do not change pkt_len.
- R8: After reset, no valid beats are captured until the first start-of-packet beat.
- R9: After reset, all outputs are 0.
- R10: pkt_len and pad_cnt hold their values until the next capture or computation replaces them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Incoming stream byte |
| in_valid | input | 1 | Incoming byte is valid |
| in_sop | input | 1 | Incoming byte is the first of a packet |
| out_data | output | 8 | Forwarded stream byte |
| out_valid | output | 1 | Forwarded byte is valid |
| out_sop | output | 1 | Forwarded byte is the first of a packet |
| pkt_len | output | 16 | Latched total-length field |
| pad_cnt | output | 6 | Pad bytes required |
| len_ready | output | 1 | One-cycle pulse: length and pad count valid |
| len_err | output | 1 | Length field below minimum |

## Verification
The assertions check several properties on every cycle. pad_cnt stays within range. Each ready pulse lasts a single cycle. During a good pulse, length plus pad plus trailer is a multiple of 48. An error always comes with a zero pad. pad_cnt changes only with a pulse, and a start-of-packet clears the flags. Only the bench scenarios can show the remaining behaviour. That includes whether the right header bytes are captured around idle gaps, before the first start-of-packet and after a start-of-packet cuts off a header, whether the forwarded stream has the exact latency, and whether specific lengths such as 20, 41 and 65535 give the right pad values.

// File: rtl/pktlen_pad_pkg.sv
package pktlen_pad_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              vld;
    logic              sop;
    logic [BYTE_W-1:0] dat;
  } plp_beat_t;
endpackage

// File: rtl/plp_beat_delay.sv
module plp_beat_delay
  import pktlen_pad_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  plp_beat_t beat_in,
  output plp_beat_t beat_out
);
  plp_beat_t stage_q [DEPTH];
  plp_beat_t stage_d [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_comb stage_d[gi] = beat_in;
      end else begin : g_rest
        always_comb stage_d[gi] = stage_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= '0;
        else        stage_q[gi] <= stage_d[gi];
      end
    end
  endgenerate

  assign beat_out = stage_q[DEPTH-1];
endmodule

// File: rtl/plp_hdr_tracker.sv
module plp_hdr_tracker #(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 16,
  parameter int HI_IDX  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [DATA_W-1:0] in_data,
  output logic [LEN_W-1:0]  len_q,
  output logic              cap_pend_q
);
  localparam int LO_IDX  = HI_IDX + 1;
  localparam int POS_MAX = LO_IDX + 1;
  localparam int POS_W   = $clog2(POS_MAX + 1);

  logic [POS_W-1:0]  pos_q, pos_d;
  logic [DATA_W-1:0] hi_q, hi_d;
  logic [LEN_W-1:0]  len_d;
  logic              pend_d;
  logic              at_hi, at_lo;

  assign at_hi = in_valid && !in_sop && (pos_q == POS_W'(HI_IDX));
  assign at_lo = in_valid && !in_sop && (pos_q == POS_W'(LO_IDX));

  always_comb begin
    pos_d  = pos_q;
    hi_d   = hi_q;
    len_d  = len_q;
    pend_d = 1'b0;
    if (in_valid) begin
      if (in_sop)                      pos_d = POS_W'(1);
      else if (pos_q < POS_W'(POS_MAX)) pos_d = pos_q + POS_W'(1);
    end
    if (at_hi) hi_d = in_data;
    if (at_lo) begin
      len_d  = LEN_W'({hi_q, in_data});
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q      <= POS_W'(POS_MAX);
      hi_q       <= '0;
      len_q      <= '0;
      cap_pend_q <= 1'b0;
    end else begin
      pos_q      <= pos_d;
      hi_q       <= hi_d;
      len_q      <= len_d;
      cap_pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/plp_pad_reducer.sv
module plp_pad_reducer #(
  parameter int LEN_W     = 16,
  parameter int CELL      = 48,
  parameter int TRAILER   = 8,
  parameter int MIN_LEN   = 20,
  parameter int PAD_W     = $clog2(CELL)
) (
  input  logic [LEN_W-1:0] len,
  output logic [PAD_W-1:0] pad,
  output logic             too_short
);
  localparam int SUM_W = LEN_W + 1;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] rem;

  always_comb begin
    sum       = {1'b0, len} + SUM_W'(TRAILER);
    rem       = sum % SUM_W'(CELL);
    too_short = (len < LEN_W'(MIN_LEN));
    if (rem == '0) pad = '0;
    else           pad = PAD_W'(SUM_W'(CELL) - rem);
  end
endmodule

// File: rtl/pktlen_pad_calc.sv
module pktlen_pad_calc
  import pktlen_pad_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int CELL    = 48,
  parameter int TRAILER = 8,
  parameter int MIN_LEN = 20,
  parameter int HI_IDX  = 2,
  parameter int FWD_LAT = 2,
  parameter int PAD_W   = $clog2(CELL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_sop,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic [LEN_W-1:0]  pkt_len,
  output logic [PAD_W-1:0]  pad_cnt,
  output logic              len_ready,
  output logic              len_err
);
  plp_beat_t beat_in, beat_out;
  logic [LEN_W-1:0] len_q;
  logic             cap_pend;
  logic [PAD_W-1:0] pad_calc;
  logic             short_calc;
  logic             sop_evt;
  logic [PAD_W-1:0] pad_q, pad_d;
  logic             rdy_q, rdy_d;
  logic             err_q, err_d;

  assign beat_in = '{vld: in_valid, sop: in_sop, dat: in_data};

  plp_beat_delay #(.DEPTH(FWD_LAT)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_in  (beat_in),
    .beat_out (beat_out)
  );

  plp_hdr_tracker #(.DATA_W(BYTE_W), .LEN_W(LEN_W), .HI_IDX(HI_IDX)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sop     (in_sop),
    .in_data    (in_data),
    .len_q      (len_q),
    .cap_pend_q (cap_pend)
  );

  plp_pad_reducer #(
    .LEN_W(LEN_W), .CELL(CELL), .TRAILER(TRAILER), .MIN_LEN(MIN_LEN), .PAD_W(PAD_W)
  ) u_pad (
    .len       (len_q),
    .pad       (pad_calc),
    .too_short (short_calc)
  );

  assign sop_evt = in_valid && in_sop;

  always_comb begin
    rdy_d = cap_pend && !sop_evt;
    pad_d = pad_q;
    err_d = err_q;
    if (rdy_d) begin
      pad_d = short_calc ? '0 : pad_calc;
      err_d = short_calc;
    end
    if (sop_evt) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q <= '0;
      rdy_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      pad_q <= pad_d;
      rdy_q <= rdy_d;
      err_q <= err_d;
    end
  end

  assign out_data  = beat_out.dat;
  assign out_valid = beat_out.vld;
  assign out_sop   = beat_out.sop;
  assign pkt_len   = len_q;
  assign pad_cnt   = pad_q;
  assign len_ready = rdy_q;
  assign len_err   = err_q;
endmodule

// File: rtl/pktlen_pad_calc_chk.sv
module pktlen_pad_calc_chk #(
  parameter int LEN_W   = 16,
  parameter int CELL    = 48,
  parameter int TRAILER = 8,
  parameter int PAD_W   = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sop,
  input logic [LEN_W-1:0] pkt_len,
  input logic [PAD_W-1:0] pad_cnt,
  input logic             len_ready,
  input logic             len_err
);
  p_pad_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pad_cnt < PAD_W'(CELL));

  p_fill_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (len_ready && !len_err) |->
      (((32'(pkt_len) + 32'(pad_cnt) + TRAILER) % CELL) == 0));

  p_ready_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    len_ready |=> !len_ready);

  p_err_zero_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (len_ready && len_err) |-> (pad_cnt == '0));

  p_err_with_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(len_err) |-> len_ready);

  p_sop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop) |=> (!len_ready && !len_err));

  p_pad_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_cnt) |-> len_ready);
endmodule

bind pktlen_pad_calc pktlen_pad_calc_chk #(
  .LEN_W(LEN_W), .CELL(CELL), .TRAILER(TRAILER), .PAD_W(PAD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sop    (in_sop),
  .pkt_len   (pkt_len),
  .pad_cnt   (pad_cnt),
  .len_ready (len_ready),
  .len_err   (len_err)
);

// File: tb/pktlen_pad_calc_tb.sv
module pktlen_pad_calc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic       clk;
  logic       rst_n;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_sop;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_sop;
  logic [15:0] pkt_len;
  logic [5:0] pad_cnt;
  logic       len_ready;
  logic       len_err;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  int ready_seen = 0;

  pktlen_pad_calc dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_sop(in_sop), .out_data(out_data), .out_valid(out_valid),
    .out_sop(out_sop), .pkt_len(pkt_len), .pad_cnt(pad_cnt),
    .len_ready(len_ready), .len_err(len_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_q[$];
  int m_pos;
  int m_hi;
  int m_len, m_pad;
  bit m_pend, m_rdy, m_err;

  function automatic int pad_of(int len);
    return (48 - ((len + 8) % 48)) % 48;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q = {};
      for (int i = 0; i < LAT; i++) m_q.push_back(0);
      m_pos = -1; m_hi = 0; m_len = 0; m_pad = 0;
      m_pend = 0; m_rdy = 0; m_err = 0;
    end else begin
      bit sop_now;
      int idx;
      sop_now = in_valid && in_sop;
      m_q.push_back({in_valid, in_sop, in_data});
      void'(m_q.pop_front());
      m_rdy = m_pend && !sop_now;
      if (m_rdy) begin
        m_err = (m_len < 20);
        m_pad = m_err ? 0 : pad_of(m_len);
      end
      if (sop_now) m_err = 0;
      m_pend = 0;
      if (in_valid) begin
        idx = in_sop ? 0 : m_pos;
        if (idx == 2) m_hi = in_data;
        if (idx == 3) begin
          m_len = m_hi * 256 + in_data;
          m_pend = 1;
        end
        if (in_sop) m_pos = 1;
        else if (m_pos >= 0 && m_pos < 4) m_pos++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1", "out_valid", out_valid, (m_q[0] >> 9) & 1);
      chk("R1", "out_sop",   out_sop,   (m_q[0] >> 8) & 1);
      chk("R1", "out_data",  out_data,  m_q[0] & 8'hff);
      chk("R2", "pkt_len",   pkt_len,   m_len);
      chk("R3", "pad_cnt",   pad_cnt,   m_pad);
      chk("R4", "len_ready", len_ready, m_rdy);
      chk("R5", "len_err",   len_err,   m_err);
      if (len_ready) ready_seen++;
    end
  end

  task automatic beat(bit v, bit s, logic [7:0] d);
    @(negedge clk);
    in_valid = v; in_sop = s; in_data = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) beat(0, 0, 8'h00);
  endtask

  task automatic send_pkt(int len, int nbytes, int gap_after);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b;
      case (i)
        0: b = 8'h45;
        1: b = 8'h00;
        2: b = 8'(len >> 8);
        3: b = 8'(len);
        default: b = 8'(i * 7);
      endcase
      beat(1, i == 0, b);
      if (i == gap_after) idle(2);
    end
    idle(3);
  endtask

  task automatic expect_pkt(string req, int len, int pad, int err, int pulses_before);
    chk(req, "pkt_len held", pkt_len, len);
    chk(req, "pad_cnt held", pad_cnt, pad);
    chk(req, "len_err held", len_err, err);
    chk("R4", "ready pulse count", ready_seen - pulses_before, 1);
  endtask

  initial begin
    int rs;
    in_valid = 0; in_sop = 0; in_data = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9", "out_valid", out_valid, 0);
    chk("R9", "pkt_len",   pkt_len,   0);
    chk("R9", "pad_cnt",   pad_cnt,   0);
    chk("R9", "len_ready", len_ready, 0);
    chk("R9", "len_err",   len_err,   0);
    @(negedge clk);
    rst_n = 1;
    idle(2);

    // R8: valid bytes before any start-of-packet are not captured
    for (int i = 0; i < 6; i++) beat(1, 0, 8'hA0 + 8'(i));
    idle(3);
    chk("R8", "pkt_len before first sop", pkt_len, 0);
    chk("R8", "no ready before first sop", ready_seen, 0);

    rs = ready_seen; send_pkt(40, 10, -1);  expect_pkt("R3", 40, 0, 0, rs);
    rs = ready_seen; send_pkt(20, 20, -1);  expect_pkt("R3", 20, 20, 0, rs);
    rs = ready_seen; send_pkt(41, 8, -1);   expect_pkt("R3", 41, 47, 0, rs);
    rs = ready_seen; send_pkt(65535, 6, -1); expect_pkt("R3", 65535, 25, 0, rs);
    // R7: idle gaps inside the header
    rs = ready_seen; send_pkt(100, 9, 1);   expect_pkt("R7", 100, 36, 0, rs);
    rs = ready_seen; send_pkt(1001, 9, 2);  expect_pkt("R7", 1001, 47, 0, rs);
    // R5: short length
    rs = ready_seen; send_pkt(19, 6, -1);   expect_pkt("R5", 19, 0, 1, rs);

    // R6: start-of-packet clears error flag
    beat(1, 1, 8'h45);
    beat(0, 0, 8'h00);
    chk("R6", "len_err cleared by sop", len_err, 0);
    idle(2);

    // R6: sop right after length byte cancels the pending computation
    rs = ready_seen;
    beat(1, 1, 8'h45); beat(1, 0, 8'h00); beat(1, 0, 8'h00); beat(1, 0, 8'd77);
    beat(1, 1, 8'h45);
    idle(4);
    chk("R6", "no ready after cancel", ready_seen - rs, 0);
    chk("R10", "pad_cnt unchanged after cancel", pad_cnt, 0);
    chk("R2", "pkt_len captured before cancel", pkt_len, 77);

    // R10: long tail does not disturb held values
    rs = ready_seen; send_pkt(500, 40, -1); expect_pkt("R10", 500, 20, 0, rs);

    idle(4);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule